// File: doc/BRIEF.md
# Codec Multimedia Serial Frame Controller

This block runs a full-duplex synchronous serial link to a combined audio and telecom codec. It makes a bit clock and a frame sync pulse. On every frame it shifts 128 bits out on a transmit line and captures 128 bits from a receive line. Each frame is two 64-bit subframes. Only the first subframe carries traffic. The second subframe is sent as zeros, and whatever arrives in it is discarded.

On transmit, the first subframe carries these fields:
- digital-to-analog conversion samples for the audio channel and the telecom channel;
- a valid flag for each sample;
- one request to read or write a codec control register.

The host supplies these fields on parallel inputs. They are copied into a shadow copy when each frame starts, so the host may change them at any time. On receive, the first subframe is split into the same fields: analog-to-digital samples, valid flags, register address and register data. When a frame ends, a one-clock strobe marks the new values. A second strobe reports that a register read has completed, but only when the returned address matches the address that was requested.

The bit clock comes from one of two sources. The first is an internal divider of the system clock, with a slow rate and a fast rate. The second is an external clock pin, which is resynchronised into the system clock domain.

Top module: `cfc_frame_ctrl`

## Requirements
- R1: With the internal source selected, the bit clock stays high and stays low for HALF_SLOW system clocks each when `rate_fast_i`=0, and for HALF_FAST system clocks each when `rate_fast_i`=1.
- R2: With `src_ext_i`=1, `bclk_o` follows `ext_bclk_i`, delayed by a fixed latency of three system clocks. Each input level lasts exactly as long at the output, and `rate_fast_i` has no effect.
- R3: `fsync_o` is high for exactly one bit-clock period, on bit 0 of each frame. Frames are 128 bits long and follow one another with no gap.
- R4: Transmit bits change on the rising edge of the bit clock and are sent MSB first. Bits 0 to 63 of a frame are:
  - bits 0 to 15: audio sample;
  - bits 16 to 31: telecom sample;
  - bit 32: audio valid;
  - bit 33: telecom valid;
  - bit 34: write flag (1 = write, 0 = read);
  - bits 35 to 38: 4-bit register address;
  - bits 39 to 54: 16-bit register data;
  - bits 55 to 63: zeros.
- R5: Bits 64 to 127 of every transmitted frame are zero.
- R6: The host fields are captured when a frame starts. A change to them during a frame does not alter that frame, and it is sent in the next frame.
- R7: Receive bits are sampled on the falling edge of the bit clock. Bits 0 to 63 are decoded with the same layout as R4 onto the `rx_*` outputs. `rx_valid_o` pulses for one system clock at the end of each frame, and the outputs hold their values until the next pulse.
- R8: The values received in bits 64 to 127 have no effect on any output.
- R9: `rd_done_o` pulses together with `rx_valid_o` only when the frame just sent had the write flag at 0 and the received address equals the address sent in that frame. It stays low for writes and for an address mismatch.
- R10: During reset `bclk_o`, `fsync_o`, `txd_o`, `rx_valid_o`, `rd_done_o` and all `rx_*` outputs are 0.
- R11: While `en_i`=0, no frame runs: `fsync_o` and `txd_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Frame engine enable |
| src_ext_i | input | 1 | Bit clock source: 0 internal divider, 1 external pin |
| rate_fast_i | input | 1 | Internal divider rate: 0 slow, 1 fast |
| ext_bclk_i | input | 1 | External bit clock input |
| bclk_o | output | 1 | Bit clock to the codec |
| fsync_o | output | 1 | Frame sync, high during bit 0 |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| tx_audio_i | input | 16 | Audio sample to send |
| tx_tel_i | input | 16 | Telecom sample to send |
| tx_audio_vld_i | input | 1 | Audio sample valid flag |
| tx_tel_vld_i | input | 1 | Telecom sample valid flag |
| tx_wr_i | input | 1 | Register request direction, 1 = write |
| tx_addr_i | input | 4 | Register address |
| tx_wdata_i | input | 16 | Register write data |
| rx_audio_o | output | 16 | Received audio sample |
| rx_tel_o | output | 16 | Received telecom sample |
| rx_audio_vld_o | output | 1 | Received audio valid flag |
| rx_tel_vld_o | output | 1 | Received telecom valid flag |
| rx_addr_o | output | 4 | Received register address |
| rx_rdata_o | output | 16 | Received register data |
| rx_valid_o | output | 1 | One-clock strobe: new received fields |
| rd_done_o | output | 1 | One-clock strobe: a register read completed with a matching address |

## Verification
The assertions assume three things about the inputs:
- `src_ext_i` and `rate_fast_i` do not change while a frame is running;
- each level of the external bit clock lasts at least two system clocks;
- `rxd_i` changes only while the bit clock is high, well away from the falling edge where it is sampled.

The stimulus changes the clock source and the rate only while `en_i` is low. It drives the external clock with three-clock half periods, and it changes `rxd_i` right after it sees a rising edge on `bclk_o`. Host fields change in the middle of a frame on purpose, because capturing them at frame start is the behaviour under test.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int SUB_BITS   = 64;
    localparam int FRAME_BITS = 2 * SUB_BITS;
    localparam int SAMPLE_W   = 16;
    localparam int ADDR_W     = 4;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // Layout of the first subframe, most significant field goes out first
    typedef struct packed {
        logic [SAMPLE_W-1:0] audio;
        logic [SAMPLE_W-1:0] tel;
        logic                audio_vld;
        logic                tel_vld;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [SAMPLE_W-1:0] data;
    } slot_t;

    localparam int SLOT_BITS = $bits(slot_t);
    localparam int PAD_BITS  = SUB_BITS - SLOT_BITS;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } bclk_src_e;

    function automatic logic [SUB_BITS-1:0] slot_to_sub(input slot_t s);
        return {s, {PAD_BITS{1'b0}}};
    endfunction

    function automatic slot_t sub_to_slot(input logic [SUB_BITS-1:0] v);
        return slot_t'(v[SUB_BITS-1 -: SLOT_BITS]);
    endfunction

endpackage

// File: rtl/cfc_bclk_gen.sv
module cfc_bclk_gen
    import cfc_pkg::*;
#(
    parameter int HALF_SLOW = 4,
    parameter int HALF_FAST = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bclk_src_e src_i,
    input  logic      rate_fast_i,
    input  logic      ext_bclk_i,
    output logic      bclk_o,
    output logic      rise_o,
    output logic      fall_o
);

    localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(HALF_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(HALF_FAST - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bclk_q;
    logic [CNT_W-1:0] lim;
    logic             toggle;

    always_comb begin
        lim = rate_fast_i ? LIM_FAST : LIM_SLOW;
        if (src_i == SRC_EXT)
            toggle = (sync_q[1] != bclk_q);
        else
            toggle = (cnt_q >= lim);
    end

    assign rise_o = toggle & ~bclk_q;
    assign fall_o = toggle &  bclk_q;
    assign bclk_o = bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_bclk_i};
            if (src_i == SRC_EXT || cnt_q >= lim)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (toggle)
                bclk_q <= ~bclk_q;
        end
    end

    AST_RISE_GOES_HIGH: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> bclk_o); // R1
    AST_FALL_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !bclk_o); // R1
    AST_HALF_NOT_SHORT: assert property (@(posedge clk) disable iff (rst)
        (src_i == SRC_INT) && $changed(bclk_q) && $stable(src_i) && $stable(rate_fast_i)
        |-> !toggle || (lim == '0)); // R1

endmodule

// File: rtl/cfc_frame_timer.sv
module cfc_frame_timer
    import cfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             rise_i,
    output logic             active_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             frame_start_o,
    output logic             fsync_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;

    assign frame_start_o = rise_i & en_i & (~active_q | (idx_q == LAST_IDX));
    assign active_o      = active_q;
    assign bit_idx_o     = idx_q;
    assign fsync_o       = active_q & (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (frame_start_o) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (rise_i && active_q) begin
            idx_q    <= idx_q + 1'b1;
        end
    end

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        rise_i && en_i && fsync_o |=> !fsync_o); // R3
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        rise_i && en_i && active_q && (idx_q == LAST_IDX) |=> fsync_o); // R3
    AST_IDLE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !fsync_o && !active_o); // R11

endmodule

// File: rtl/cfc_tx_path.sv
module cfc_tx_path
    import cfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             frame_start_i,
    input  logic             active_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  slot_t            host_i,
    output slot_t            cur_cmd_o,
    output logic             txd_o
);

    localparam logic [IDX_W-1:0] SUB_LIM = IDX_W'(SUB_BITS);

    slot_t               shadow_q;
    logic [SUB_BITS-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            shift_q  <= '0;
        end else if (frame_start_i) begin
            shadow_q <= host_i;
            shift_q  <= slot_to_sub(host_i);
        end else if (rise_i && active_i) begin
            shift_q  <= {shift_q[SUB_BITS-2:0], 1'b0};
        end
    end

    assign txd_o     = active_i & shift_q[SUB_BITS-1];
    assign cur_cmd_o = shadow_q;

    AST_TX_SECOND_ZERO: assert property (@(posedge clk) disable iff (rst)
        active_i && (bit_idx_i >= SUB_LIM) |-> !txd_o); // R5
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start_i |=> $stable(shadow_q)); // R6

endmodule

// File: rtl/cfc_rx_path.sv
module cfc_rx_path
    import cfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic             active_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             rxd_i,
    input  slot_t            cur_cmd_i,
    output slot_t            rx_slot_o,
    output logic             rx_valid_o,
    output logic             rd_done_o
);

    localparam logic [IDX_W-1:0] SUB_LIM  = IDX_W'(SUB_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [SUB_BITS-1:0] shift_q;
    slot_t               slot_q;
    logic                valid_q;
    logic                done_q;
    slot_t               arrived;
    logic                in_first;
    logic                frame_end;

    always_comb begin
        arrived   = sub_to_slot(shift_q);
        in_first  = (bit_idx_i < SUB_LIM);
        frame_end = fall_i & active_i & (bit_idx_i == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            slot_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            if (fall_i && active_i && in_first)
                shift_q <= {shift_q[SUB_BITS-2:0], rxd_i};
            if (frame_end) begin
                slot_q  <= arrived;
                valid_q <= 1'b1;
                done_q  <= ~cur_cmd_i.wr & (arrived.addr == cur_cmd_i.addr);
            end
        end
    end

    assign rx_slot_o  = slot_q;
    assign rx_valid_o = valid_q;
    assign rd_done_o  = done_q;

    AST_RX_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R7
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(slot_q)); // R7
    AST_SECOND_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !in_first |=> $stable(shift_q)); // R8
    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_done_o |-> rx_valid_o); // R9

endmodule

// File: rtl/cfc_frame_ctrl.sv
module cfc_frame_ctrl
    import cfc_pkg::*;
#(
    parameter int HALF_SLOW = 4,
    parameter int HALF_FAST = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                src_ext_i,
    input  logic                rate_fast_i,
    input  logic                ext_bclk_i,
    output logic                bclk_o,
    output logic                fsync_o,
    output logic                txd_o,
    input  logic                rxd_i,
    input  logic [SAMPLE_W-1:0] tx_audio_i,
    input  logic [SAMPLE_W-1:0] tx_tel_i,
    input  logic                tx_audio_vld_i,
    input  logic                tx_tel_vld_i,
    input  logic                tx_wr_i,
    input  logic [ADDR_W-1:0]   tx_addr_i,
    input  logic [SAMPLE_W-1:0] tx_wdata_i,
    output logic [SAMPLE_W-1:0] rx_audio_o,
    output logic [SAMPLE_W-1:0] rx_tel_o,
    output logic                rx_audio_vld_o,
    output logic                rx_tel_vld_o,
    output logic [ADDR_W-1:0]   rx_addr_o,
    output logic [SAMPLE_W-1:0] rx_rdata_o,
    output logic                rx_valid_o,
    output logic                rd_done_o
);

    bclk_src_e        src;
    logic             rise, fall;
    logic             active, frame_start;
    logic [IDX_W-1:0] bit_idx;
    slot_t            host_slot, cur_cmd, rx_slot;

    assign src = src_ext_i ? SRC_EXT : SRC_INT;

    always_comb begin
        host_slot.audio     = tx_audio_i;
        host_slot.tel       = tx_tel_i;
        host_slot.audio_vld = tx_audio_vld_i;
        host_slot.tel_vld   = tx_tel_vld_i;
        host_slot.wr        = tx_wr_i;
        host_slot.addr      = tx_addr_i;
        host_slot.data      = tx_wdata_i;
    end

    cfc_bclk_gen #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_FAST (HALF_FAST)
    ) u_bclk (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .rate_fast_i (rate_fast_i),
        .ext_bclk_i  (ext_bclk_i),
        .bclk_o      (bclk_o),
        .rise_o      (rise),
        .fall_o      (fall)
    );

    cfc_frame_timer u_timer (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .rise_i        (rise),
        .active_o      (active),
        .bit_idx_o     (bit_idx),
        .frame_start_o (frame_start),
        .fsync_o       (fsync_o)
    );

    cfc_tx_path u_tx (
        .clk           (clk),
        .rst           (rst),
        .rise_i        (rise),
        .frame_start_i (frame_start),
        .active_i      (active),
        .bit_idx_i     (bit_idx),
        .host_i        (host_slot),
        .cur_cmd_o     (cur_cmd),
        .txd_o         (txd_o)
    );

    cfc_rx_path u_rx (
        .clk        (clk),
        .rst        (rst),
        .fall_i     (fall),
        .active_i   (active),
        .bit_idx_i  (bit_idx),
        .rxd_i      (rxd_i),
        .cur_cmd_i  (cur_cmd),
        .rx_slot_o  (rx_slot),
        .rx_valid_o (rx_valid_o),
        .rd_done_o  (rd_done_o)
    );

    assign rx_audio_o     = rx_slot.audio;
    assign rx_tel_o       = rx_slot.tel;
    assign rx_audio_vld_o = rx_slot.audio_vld;
    assign rx_tel_vld_o   = rx_slot.tel_vld;
    assign rx_addr_o      = rx_slot.addr;
    assign rx_rdata_o     = rx_slot.data;

    AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !txd_o); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !fsync_o && !rx_valid_o && !rd_done_o && !bclk_o); // R10

endmodule

// File: tb/cfc_frame_ctrl_bench.sv
`timescale 1ns/100ps
module cfc_frame_ctrl_bench;

    localparam int HS = 4;
    localparam int HF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, src_ext = 1'b0, rate_fast = 1'b0, ext_bclk = 1'b0, rxd = 1'b0;
    logic [15:0] tx_audio = '0, tx_tel = '0, tx_wdata = '0;
    logic        tx_av = 1'b0, tx_tv = 1'b0, tx_wr = 1'b0;
    logic [3:0]  tx_addr = '0;
    logic bclk, fsync, txd, rx_valid, rd_done, rx_av, rx_tv;
    logic [15:0] rx_audio, rx_tel, rx_rdata;
    logic [3:0]  rx_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic bclk_prev = 1'b0;

    always #2.5 clk = ~clk;

    cfc_frame_ctrl #(.HALF_SLOW(HS), .HALF_FAST(HF)) u_cfc_frame_ctrl (
        .clk(clk), .rst(rst), .en_i(en), .src_ext_i(src_ext), .rate_fast_i(rate_fast),
        .ext_bclk_i(ext_bclk), .bclk_o(bclk), .fsync_o(fsync), .txd_o(txd), .rxd_i(rxd),
        .tx_audio_i(tx_audio), .tx_tel_i(tx_tel), .tx_audio_vld_i(tx_av), .tx_tel_vld_i(tx_tv),
        .tx_wr_i(tx_wr), .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata),
        .rx_audio_o(rx_audio), .rx_tel_o(rx_tel), .rx_audio_vld_o(rx_av), .rx_tel_vld_o(rx_tv),
        .rx_addr_o(rx_addr), .rx_rdata_o(rx_rdata), .rx_valid_o(rx_valid), .rd_done_o(rd_done)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // independent model of the first-subframe layout
    function automatic logic [63:0] mk_sub(input logic [15:0] a, input logic [15:0] t,
                                           input logic av, input logic tv, input logic wr,
                                           input logic [3:0] ad, input logic [15:0] d);
        return {a, t, av, tv, wr, ad, d, 9'd0};
    endfunction

    task automatic set_host(input logic [63:0] s);
        {tx_audio, tx_tel, tx_av, tx_tv, tx_wr, tx_addr, tx_wdata} = s[63:9];
    endtask

    task automatic wait_change(output logic lv);
        forever begin
            @(negedge clk);
            if (bclk !== bclk_prev) begin
                bclk_prev = bclk;
                lv = bclk;
                break;
            end
        end
    endtask

    task automatic run_frame(input logic [127:0] rxb, input bit chg, input logic [63:0] chg_val,
                             output logic [127:0] txb, output int sync_bad,
                             output int vld_cnt, output logic done_end);
        logic lv;
        sync_bad = 0; vld_cnt = 0; done_end = 1'b0; txb = '0;
        do wait_change(lv); while (!(lv === 1'b1 && fsync === 1'b1));
        for (int i = 0; i < 128; i++) begin
            if (i > 0) do wait_change(lv); while (lv !== 1'b1);
            rxd = rxb[127-i];
            if (chg && i == 20) set_host(chg_val);
            wait_change(lv);
            txb[127-i] = txd;
            if (fsync !== (i == 0)) sync_bad++;
            if (rx_valid === 1'b1) vld_cnt++;
            if (i == 127) done_end = rd_done;
        end
    endtask

    function automatic logic [63:0] rx_now();
        return {rx_audio, rx_tel, rx_av, rx_tv, 1'b0, rx_addr, rx_rdata, 9'd0};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 outputs in reset", {bclk, fsync, txd, rx_valid, rd_done, rx_av, rx_tv},
            7'd0);
        chk("R10 rx fields in reset", {rx_audio, rx_tel, rx_addr, rx_rdata}, '0);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_idle();
        int hits = 0;
        set_host({64{1'b1}});
        en = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (fsync === 1'b1 || txd === 1'b1) hits++;
        end
        chk("R11 idle fsync/txd", hits, 0);
    endtask

    task automatic measure_high(output int n);
        logic lv;
        do wait_change(lv); while (lv !== 1'b1);
        n = 0;
        do begin n++; wait_change(lv); end while (0);
        // count clocks from rise to fall
        n = 0;
        do wait_change(lv); while (lv !== 1'b1);
        forever begin
            @(negedge clk);
            n++;
            if (bclk !== bclk_prev) begin bclk_prev = bclk; break; end
        end
    endtask

    task automatic t_rate();
        int n;
        src_ext = 1'b0; rate_fast = 1'b0;
        repeat (20) @(negedge clk);
        measure_high(n);
        chk("R1 slow half period", n, HS);
        rate_fast = 1'b1;
        repeat (20) @(negedge clk);
        measure_high(n);
        chk("R1 fast half period", n, HF);
        rate_fast = 1'b0;
    endtask

    task automatic t_ext();
        int last = -1, bad = 0, edges = 0;
        src_ext = 1'b1; rate_fast = 1'b1;
        for (int c = 0; c < 120; c++) begin
            @(negedge clk);
            if (bclk !== bclk_prev) begin
                bclk_prev = bclk;
                if (c > 10) begin
                    if (last >= 0 && (c - last) != 3) bad++;
                    last = c;
                    edges++;
                end
            end
            if (c % 3 == 2) ext_bclk = ~ext_bclk;
        end
        chk("R2 external edge spacing", bad, 0);
        chk("R2 external edges seen", edges > 30, 1);
        src_ext = 1'b0; rate_fast = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_frames();
        logic [127:0] txb;
        int sb, vc;
        logic dn;
        logic [63:0] ha, hb, hc, ra, rb, rc;
        ha = mk_sub(16'hA5C3, 16'h0F1E, 1'b1, 1'b0, 1'b1, 4'h3, 16'hBEEF);
        hb = mk_sub(16'h1357, 16'h2468, 1'b0, 1'b1, 1'b0, 4'h5, 16'h0000);
        hc = mk_sub(16'hFFFF, 16'h8001, 1'b1, 1'b1, 1'b0, 4'h9, 16'h7777);
        ra = mk_sub(16'h4321, 16'h8765, 1'b1, 1'b1, 1'b0, 4'h3, 16'hCAFE);
        rb = mk_sub(16'h0A0B, 16'h0C0D, 1'b0, 1'b1, 1'b0, 4'h5, 16'h1234);
        rc = mk_sub(16'h5555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 4'h6, 16'h9999);
        set_host(ha);
        en = 1'b1;
        run_frame({ra, 64'hDEAD_BEEF_0123_4567}, 1'b0, '0, txb, sb, vc, dn);
        chk("R4 tx first subframe write cmd", txb[127:64], ha);
        chk("R5 tx second subframe zero", txb[63:0], 64'd0);
        chk("R3 fsync only on bit 0", sb, 0);
        chk("R7 one rx_valid per frame", vc, 1);
        chk("R7 R8 rx fields decode", rx_now(), ra);
        chk("R9 no done on write", dn, 1'b0);
        set_host(hb);
        run_frame({rb, {64{1'b1}}}, 1'b1, hc, txb, sb, vc, dn);
        chk("R6 frame keeps captured fields", txb[127:64], hb);
        chk("R9 done on matching read", dn, 1'b1);
        chk("R7 R8 rx read data", {rx_addr, rx_rdata}, {4'h5, 16'h1234});
        chk("R3 fsync second frame", sb, 0);
        run_frame({rc, 64'h0123_4567_89AB_CDEF}, 1'b0, '0, txb, sb, vc, dn);
        chk("R6 mid-frame change sent next", txb[127:64], hc);
        chk("R5 tx zero after change", txb[63:0], 64'd0);
        chk("R9 no done on address mismatch", dn, 1'b0);
        chk("R8 rx ignores second half", rx_now(), rc);
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 disable stops sync", {fsync, txd}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_rate();
        t_ext();
        t_frames();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule